// File: doc/BRIEF.md
# Per-Line One-Hot Response Signature Compactor

This block folds the answers a k-class inference engine gives during a self-test session into a compact set of signatures. Each answer is a k-bit label in which exactly one bit should be set. Every label bit position has its own 16-bit serial signature register. On each cycle with response-valid high, that register absorbs its bit. Over a whole session, each output line therefore builds a signature of the bit stream it carried.

When the session ends, the controller supplies the expected fault-free signature for every line on a wide parallel input and pulses compare. One cycle later the block shows which lines disagree and raises a global fail flag. The flag is also forced by a sticky error that records any valid label with no bit set or with more than one bit set. A clear pulse starts a fresh session. An erroneous stream goes undetected only when its signature aliases onto the good one, which has a chance of roughly one in 65536.

Top module: `resp_sig_compactor`

## Requirements
- R1: After reset or after a cycle with `clear_i` high, every line signature is all zeros, `mism_o` is zero, `cmp_done_o`, `onehot_err_o` and `fail_o` are low.
- R2: In a cycle with `resp_vld_i` high and `clear_i` low, line i takes bit `resp_i[i]`. With fb = sig[15] XOR that bit, the next signature is (sig shifted one place toward the MSB, with 0 entering bit 0) XOR (fb ? 16'h0291 : 0). The mask 16'h0291 holds the coefficients of x^0, x^4, x^7 and x^9 of the polynomial x^16 + x^9 + x^7 + x^4 + 1.
- R3: In a cycle with `resp_vld_i` low and `clear_i` low, no signature changes, whatever `resp_i` carries.
- R4: Lines are independent. The signature of line i depends only on the stream of `resp_i[i]`, and it is compared only with `golden_i[16*i+15 : 16*i]`.
- R5: On the clock edge after a cycle with `cmp_i` high and `clear_i` low, `cmp_done_o` is high and `mism_o[i]` is 1 exactly when line i's signature differs from its golden value. The signature used is the one held before any update in that same cycle. `cmp_done_o` is high only in such cycles.
- R6: `fail_o` is high exactly when `mism_o` has any bit set or `onehot_err_o` is high.
- R7: A cycle with `resp_vld_i` high, `clear_i` low and a `resp_i` whose number of set bits is not exactly one sets `onehot_err_o`. The flag stays set until clear. Labels presented with `resp_vld_i` low are never checked.
- R8: `clear_i` has priority over `resp_vld_i` and `cmp_i` in the same cycle; the result is the state of R1.
- R9: `mism_o` holds its value through cycles without compare and without clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Start a new session (clears all state) |
| resp_vld_i | input | 1 | Label on `resp_i` is valid this cycle |
| resp_i | input | K | Classification label, one bit per class line |
| cmp_i | input | 1 | Compare signatures with golden values |
| golden_i | input | K*16 | Expected signatures, line i at bits 16*i+15 down to 16*i |
| mism_o | output | K | Per-line mismatch result of the last compare |
| cmp_done_o | output | 1 | Compare result valid (one cycle after `cmp_i`) |
| onehot_err_o | output | 1 | Sticky flag: an invalid label was seen |
| fail_o | output | 1 | Any mismatch or label error |

## Verification
The embedded properties assume a reset at time zero. They also assume that `golden_i` stays steady during the cycle in which `cmp_i` is sampled. No property assumes that labels are one-hot, because detecting broken labels is part of the block's job. The bench therefore mixes legal one-hot labels with zero-hot and multi-hot labels, and applies garbage labels while valid is low. It drives golden values either equal to the reference signatures or with chosen lines perturbed, so that each line's signature is observed through the compare path alone.

// File: rtl/sigc_pkg.sv
package sigc_pkg;
   // default signature width and Galois feedback mask (x^16+x^9+x^7+x^4+1)
   localparam int unsigned   SIG_W_DEF = 16;
   localparam logic [15:0]   POLY_DEF  = 16'h0291;
   localparam int unsigned   LINES_DEF = 10;
endpackage

// File: rtl/sigc_line.sv
module sigc_line #(
   parameter int unsigned      W    = 16,
   parameter logic [W-1:0]     POLY = 16'h0291
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         upd_i,
   input  logic         bit_i,
   output logic [W-1:0] sig_o
);
   logic [W-1:0] sig_q;
   logic [W-1:0] sig_nxt;
   logic         fb;

   always_comb begin
      fb      = sig_q[W-1] ^ bit_i;
      sig_nxt = {sig_q[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sig_q <= '0;
      else if (clr_i)   sig_q <= '0;
      else if (upd_i)   sig_q <= sig_nxt;
   end

   assign sig_o = sig_q;

   // R1
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (sig_o == '0));
   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !upd_i) |=> $stable(sig_o));
endmodule

// File: rtl/sigc_onehot_mon.sv
module sigc_onehot_mon #(
   parameter int unsigned K = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         vld_i,
   input  logic [K-1:0] resp_i,
   output logic         err_o
);
   logic err_q;
   logic seen_one;
   logic seen_many;
   logic bad;

   always_comb begin
      seen_one  = 1'b0;
      seen_many = 1'b0;
      for (int i = 0; i < K; i++) begin
         if (resp_i[i]) begin
            if (seen_one) seen_many = 1'b1;
            seen_one = 1'b1;
         end
      end
      bad = !seen_one || seen_many;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               err_q <= 1'b0;
      else if (clr_i)           err_q <= 1'b0;
      else if (vld_i && bad)    err_q <= 1'b1;
   end

   assign err_o = err_q;

   // R7
   bad_label_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && !clr_i && ($countones(resp_i) != 1)) |=> err_o);
   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !clr_i) |=> err_o);
endmodule

// File: rtl/sigc_cmp.sv
module sigc_cmp #(
   parameter int unsigned K = 10,
   parameter int unsigned W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_i,
   input  logic                 cmp_i,
   input  logic [K-1:0][W-1:0]  sig_i,
   input  logic [K*W-1:0]       gold_i,
   output logic [K-1:0]         mism_o,
   output logic                 done_o
);
   logic done_q;

   for (genvar g = 0; g < K; g++) begin : g_line
      logic mism_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        mism_q <= 1'b0;
         else if (clr_i)    mism_q <= 1'b0;
         else if (cmp_i)    mism_q <= (sig_i[g] != gold_i[g*W +: W]);
      end
      assign mism_o[g] = mism_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  done_q <= 1'b0;
      else         done_q <= cmp_i && !clr_i;
   end

   assign done_o = done_q;

   // R5
   done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_i && !clr_i) |=> done_o);
   // R9
   mism_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_i && !clr_i) |=> $stable(mism_o));
   // R8
   clr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (mism_o == '0 && !done_o));
endmodule

// File: rtl/resp_sig_compactor.sv
module resp_sig_compactor
   import sigc_pkg::*;
#(
   parameter int unsigned          K    = LINES_DEF,
   parameter int unsigned          W    = SIG_W_DEF,
   parameter logic [W-1:0]         POLY = W'(POLY_DEF)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             resp_vld_i,
   input  logic [K-1:0]     resp_i,
   input  logic             cmp_i,
   input  logic [K*W-1:0]   golden_i,
   output logic [K-1:0]     mism_o,
   output logic             cmp_done_o,
   output logic             onehot_err_o,
   output logic             fail_o
);
   localparam int unsigned GOLD_W = K * W;

   if (K < 2) begin : g_bad_k
      $error("resp_sig_compactor: K must be at least 2");
   end
   if (W < 2) begin : g_bad_w
      $error("resp_sig_compactor: W must be at least 2");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("resp_sig_compactor: feedback mask needs the x^0 term");
   end

   logic [K-1:0][W-1:0] sig_w;
   logic                oh_err;

   for (genvar g = 0; g < K; g++) begin : g_sig
      sigc_line #(.W(W), .POLY(POLY)) u_line (
         .clk   (clk),
         .rst_n (rst_n),
         .clr_i (clear_i),
         .upd_i (resp_vld_i),
         .bit_i (resp_i[g]),
         .sig_o (sig_w[g])
      );
   end

   sigc_onehot_mon #(.K(K)) u_oh (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clear_i),
      .vld_i  (resp_vld_i),
      .resp_i (resp_i),
      .err_o  (oh_err)
   );

   sigc_cmp #(.K(K), .W(W)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clear_i),
      .cmp_i  (cmp_i),
      .sig_i  (sig_w),
      .gold_i (golden_i[GOLD_W-1:0]),
      .mism_o (mism_o),
      .done_o (cmp_done_o)
   );

   assign onehot_err_o = oh_err;
   assign fail_o       = oh_err || (|mism_o);

   // R6
   err_forces_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      onehot_err_o |-> fail_o);
   // R6
   mism_forces_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mism_o != '0) |-> fail_o);
endmodule

// File: tb/resp_sig_compactor_tb_top.sv
`timescale 1ns/1ps
module resp_sig_compactor_tb_top;
   localparam int K = 10;
   localparam int W = 16;
   localparam logic [15:0] MASK = 16'h0291;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           clear = 1'b0;
   logic           vld = 1'b0;
   logic [K-1:0]   resp = '0;
   logic           cmp = 1'b0;
   logic [K*W-1:0] gold = '0;
   logic [K-1:0]   mism;
   logic           done, oh_err, fail;

   always #4 clk = ~clk;

   resp_sig_compactor dut_i (
      .clk(clk), .rst_n(rst_n), .clear_i(clear), .resp_vld_i(vld),
      .resp_i(resp), .cmp_i(cmp), .golden_i(gold), .mism_o(mism),
      .cmp_done_o(done), .onehot_err_o(oh_err), .fail_o(fail)
   );

   // reference model
   logic [15:0]  m_sig [K];
   logic         m_err;
   logic [K-1:0] m_mism;
   logic         m_done;

   int    n_chk = 0;
   int    n_bad = 0;
   string tag = "R1";

   task automatic chk(input bit ok, input string t, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < K; i++) m_sig[i] = '0;
      m_err = 1'b0; m_mism = '0; m_done = 1'b0;
   endtask

   task automatic model_edge();
      if (clear) begin
         model_clear();
      end else begin
         if (cmp) begin
            for (int i = 0; i < K; i++)
               m_mism[i] = (m_sig[i] != gold[i*W +: W]);
            m_done = 1'b1;
         end else begin
            m_done = 1'b0;
         end
         if (vld) begin
            if ($countones(resp) != 1) m_err = 1'b1;
            for (int i = 0; i < K; i++) begin
               logic fb;
               fb = m_sig[i][15] ^ resp[i];
               m_sig[i] = {m_sig[i][14:0], 1'b0} ^ (fb ? MASK : 16'h0000);
            end
         end
      end
   endtask

   task automatic compare_all();
      chk(mism == m_mism, tag, "mism_o", 32'(mism), 32'(m_mism));
      chk(done == m_done, "R5", "cmp_done_o", 32'(done), 32'(m_done));
      chk(oh_err == m_err, "R7", "onehot_err_o", 32'(oh_err), 32'(m_err));
      chk(fail == (m_err || (|m_mism)), "R6", "fail_o", 32'(fail),
          32'(m_err || (|m_mism)));
   endtask

   task automatic step();
      @(posedge clk);
      model_edge();
      #1;
      compare_all();
   endtask

   task automatic drive(input logic c, input logic v, input logic [K-1:0] r,
                        input logic p);
      clear = c; vld = v; resp = r; cmp = p;
   endtask

   task automatic set_gold(input logic [K-1:0] flip);
      for (int i = 0; i < K; i++)
         gold[i*W +: W] = m_sig[i] ^ (flip[i] ? 16'h8001 : 16'h0000);
   endtask

   function automatic logic [K-1:0] rand_hot();
      return K'(1) << ($urandom % K);
   endfunction

   task automatic do_compare(input logic [K-1:0] flip);
      set_gold(flip);
      drive(0, 0, '0, 1);
      step();
      chk(mism == flip, tag, "compare result", 32'(mism), 32'(flip));
      drive(0, 0, '0, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R1 watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      model_clear();
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      // R1: reset state
      tag = "R1";
      compare_all();
      do_compare('0);

      // R2: session of valid one-hot labels with idle gaps
      tag = "R2";
      for (int n = 0; n < 60; n++) begin
         drive(0, ($urandom % 2) == 0, rand_hot(), 0);
         step();
      end
      drive(0, 0, '0, 0);
      do_compare('0);

      // R4: perturbed golden on lines 3 and 7 only
      tag = "R4";
      do_compare(10'b0010001000);
      // R9: result holds without compare
      tag = "R9";
      repeat (4) begin
         step();
         chk(mism == 10'b0010001000, "R9", "held mism", 32'(mism), 32'h88);
      end
      chk(fail == 1'b1, "R6", "fail on mismatch", 32'(fail), 1);

      // R3: garbage labels with valid low change nothing
      tag = "R3";
      for (int n = 0; n < 8; n++) begin
         drive(0, 0, K'($urandom), 0);
         step();
      end
      drive(0, 0, '0, 0);
      do_compare('0);
      chk(oh_err == 1'b0, "R7", "no check while valid low", 32'(oh_err), 0);

      // R5: compare in same cycle as update uses pre-update signature
      tag = "R5";
      set_gold('0);
      drive(0, 1, 10'b0000000001, 1);
      step();
      chk(mism == '0, "R5", "pre-update compare", 32'(mism), 0);
      drive(0, 0, '0, 0);
      step();
      chk(done == 1'b0, "R5", "done single cycle", 32'(done), 0);

      // R7: zero-hot label
      tag = "R7";
      drive(0, 1, '0, 0);
      step();
      chk(oh_err == 1'b1, "R7", "zero-hot", 32'(oh_err), 1);
      chk(fail == 1'b1, "R6", "fail on label error", 32'(fail), 1);
      drive(0, 1, rand_hot(), 0);
      step();
      chk(oh_err == 1'b1, "R7", "sticky", 32'(oh_err), 1);

      // R1: clear restores initial state
      tag = "R1";
      drive(1, 0, '0, 0);
      step();
      chk(oh_err == 1'b0 && fail == 1'b0, "R1", "after clear", 32'(fail), 0);
      // R7: two-hot label
      drive(0, 1, 10'b0100000100, 0);
      step();
      chk(oh_err == 1'b1, "R7", "two-hot", 32'(oh_err), 1);

      // R8: clear beats valid and compare
      tag = "R8";
      gold = '1;
      drive(1, 1, 10'b1100000000, 1);
      step();
      chk(done == 1'b0 && oh_err == 1'b0, "R8", "clear priority",
          32'({done, oh_err}), 0);
      drive(0, 0, '0, 0);
      do_compare('0);
      gold = '0;
      drive(0, 0, '0, 1);
      step();
      chk(mism == '0, "R8", "signatures zero after clear", 32'(mism), 0);
      drive(0, 0, '0, 0);

      // long random mix
      tag = "R5";
      for (int n = 0; n < 3000; n++) begin
         int sel;
         logic [K-1:0] r;
         sel = $urandom % 100;
         r = (sel < 3) ? K'($urandom) : rand_hot();
         if ((sel % 7) == 0)
            set_gold((sel < 50) ? '0 : K'($urandom));
         drive(sel == 99, ($urandom % 3) != 0, r, (sel % 7) == 0);
         step();
      end
      drive(0, 0, '0, 0);
      step();

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule